// File: doc/BRIEF.md
# Flash Page-Program Write Engine

This block takes bytes from a small host register interface and programs them into a serial NOR flash over a single-lane SPI link. It has two modes, chosen by a buffer-enable bit. With the buffer off, each trigger programs exactly one byte, taken from a byte data register. With the buffer on, software first loads up to 256 bytes as 32-bit pushes into an on-chip page buffer. One trigger then programs every loaded byte in a single page-program frame.

For every program operation the engine sends a write-enable frame. It then sends the page-program frame, which carries a 24-bit address, most significant byte first, followed by the data. After that it polls the flash status register until the write-in-progress bit reads zero. Only then does it clear the trigger bit. Software sees completion by reading the trigger bit back. An optional step flag advances the stored address by one after each single-byte operation, so a run of bytes can be written without reloading the address.

Register map (word index on `reg_addr_i`): 0 control (bit 4 trigger, bit 7 step), 1 address bits 7:0, 2 address bits 15:8, 3 address bits 23:16, 4 byte data, 5 buffer control (bit 0 enable), 6 buffer push (write only), 7 buffer fill level in words (read only).

Top module: `flash_page_writer`

## Requirements
- R1: After reset the control register reads 0, the fill level reads 0, chip select is high and the serial clock is low.
- R2: With the buffer disabled, writing 1 to control bit 4 sends one write-enable frame (0x06). It then sends one page-program frame (0x02) that carries exactly one data byte, the value of the byte data register.
- R3: The 24-bit address is built from three byte registers: index 1 holds bits 7:0, index 2 holds bits 15:8 and index 3 holds bits 23:16. The address goes onto the wire most significant byte first.
- R4: With the buffer enabled, 64 pushes to register 6 fill a 256-byte page. Bits 7:0 of each word are the lowest-addressed byte and bits 31:24 the highest. One trigger programs all 256 bytes in one page-program frame.
- R5: A page trigger programs only the words actually loaded, four bytes each. A page trigger with zero words loaded clears the trigger bit without sending any frame.
- R6: After the program frame the engine repeats read-status frames (0x05 then one read byte) until status bit 0 reads 0. The trigger bit clears only after that, and chip select is high when it clears.
- R7: When the step bit (control bit 7) is set in single-byte mode, the stored address increases by one after each completed byte, with carry across the byte registers. In page mode the address is unchanged. The step bit stays set after the trigger clears.
- R8: Writing 1 to buffer-control bit 0 resets the fill level to 0. Pushes beyond 64 words are ignored. The fill level returns to 0 after a page operation completes.
- R9: While the trigger bit is set, all register writes are ignored.
- R10: The serial link runs in SPI mode 0, most significant bit first. The serial clock stays low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
A behavioural flash model in the bench decodes every frame and keeps a sparse memory. It also holds its busy flag for three status reads after each program. Single bytes are tried at a fixed address and in a stepping run that crosses a byte-register carry, which tells the address order and the increment apart. Pages are tried full, partial and empty, and with more than 64 pushes. A per-byte arithmetic pattern exposes any lane swap or off-by-one in the word pointer. Writes issued during a busy operation are read back afterwards to show they had no effect.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_ADR0  = 3'd1;
  localparam logic [2:0] RA_ADR1  = 3'd2;
  localparam logic [2:0] RA_ADR2  = 3'd3;
  localparam logic [2:0] RA_BYTE  = 3'd4;
  localparam logic [2:0] RA_BUFC  = 3'd5;
  localparam logic [2:0] RA_PUSH  = 3'd6;
  localparam logic [2:0] RA_FILL  = 3'd7;

  localparam int GO_BIT   = 4;
  localparam int STEP_BIT = 7;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_GAP1, S_PROG, S_GAP2, S_POLL, S_DONE
  } seq_state_e;
endpackage

// File: rtl/fpw_buf.sv
module fpw_buf #(
  parameter int PAGE_WORDS = 64,
  localparam int WIDX_W = $clog2(PAGE_WORDS)
) (
  input  logic              clk_i,
  input  logic              push_i,
  input  logic [WIDX_W-1:0] waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [WIDX_W-1:0] raddr_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] mem_q [PAGE_WORDS];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fpw_regs.sv
module fpw_regs
  import fpw_pkg::*;
#(
  parameter int PAGE_WORDS = 64,
  localparam int WIDX_W = $clog2(PAGE_WORDS),
  localparam int FILL_W = $clog2(PAGE_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              done_i,
  output logic              go_o,
  output logic              page_o,
  output logic [23:0]       flash_addr_o,
  output logic [7:0]        byte_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              push_o,
  output logic [WIDX_W-1:0] push_idx_o
);
  logic             go_q, step_q, bufen_q;
  logic [7:0]       adr_q [3];
  logic [7:0]       byte_q;
  logic [FILL_W-1:0] fill_q;
  logic             wr_ok, room;
  logic [23:0]      adr_cat, adr_inc;

  assign wr_ok   = we_i && !go_q;
  assign room    = fill_q < FILL_W'(PAGE_WORDS);
  assign push_o  = wr_ok && addr_i == RA_PUSH && bufen_q && room;
  assign push_idx_o = WIDX_W'(fill_q);
  assign adr_cat = {adr_q[2], adr_q[1], adr_q[0]};
  assign adr_inc = adr_cat + 24'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q    <= 1'b0;
      step_q  <= 1'b0;
      bufen_q <= 1'b0;
      byte_q  <= '0;
      fill_q  <= '0;
      for (int i = 0; i < 3; i++) adr_q[i] <= '0;
    end else if (done_i) begin
      go_q <= 1'b0;
      if (bufen_q) fill_q <= '0;
      else if (step_q) begin
        adr_q[0] <= adr_inc[7:0];
        adr_q[1] <= adr_inc[15:8];
        adr_q[2] <= adr_inc[23:16];
      end
    end else if (wr_ok) begin
      case (addr_i)
        RA_CTRL: begin
          go_q   <= wdata_i[GO_BIT];
          step_q <= wdata_i[STEP_BIT];
        end
        RA_ADR0: adr_q[0] <= wdata_i[7:0];
        RA_ADR1: adr_q[1] <= wdata_i[7:0];
        RA_ADR2: adr_q[2] <= wdata_i[7:0];
        RA_BYTE: byte_q   <= wdata_i[7:0];
        RA_BUFC: begin
          bufen_q <= wdata_i[0];
          if (wdata_i[0]) fill_q <= '0;
        end
        RA_PUSH: if (push_o) fill_q <= fill_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rdata_o[GO_BIT]   = go_q;
        rdata_o[STEP_BIT] = step_q;
      end
      RA_ADR0: rdata_o[7:0] = adr_q[0];
      RA_ADR1: rdata_o[7:0] = adr_q[1];
      RA_ADR2: rdata_o[7:0] = adr_q[2];
      RA_BYTE: rdata_o[7:0] = byte_q;
      RA_BUFC: rdata_o[0]   = bufen_q;
      RA_FILL: rdata_o[FILL_W-1:0] = fill_q;
      default: ;
    endcase
  end

  assign go_o         = go_q;
  assign page_o       = bufen_q;
  assign flash_addr_o = adr_cat;
  assign byte_o       = byte_q;
  assign fill_o       = fill_q;
endmodule

// File: rtl/fpw_shift.sv
module fpw_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic [7:0] sh_q;
  logic [2:0] bit_q;
  logic       ph_q, act_q, done_q;

  // phase 0: drive bit with clock low; phase 1: clock high, sample at its end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      ph_q   <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !act_q) begin
        sh_q  <= tx_i;
        bit_q <= '0;
        ph_q  <= 1'b0;
        act_q <= 1'b1;
      end else if (act_q) begin
        if (!ph_q) ph_q <= 1'b1;
        else begin
          ph_q  <= 1'b0;
          sh_q  <= {sh_q[6:0], miso_i};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck_o  = act_q && ph_q;
  assign mosi_o = sh_q[7];
  assign done_o = done_q;
  assign rx_o   = sh_q;
endmodule

// File: rtl/fpw_seq.sv
module fpw_seq
  import fpw_pkg::*;
#(
  parameter int PAGE_WORDS = 64,
  localparam int WIDX_W = $clog2(PAGE_WORDS),
  localparam int FILL_W = $clog2(PAGE_WORDS + 1),
  localparam int IDX_W  = $clog2(4 * PAGE_WORDS + 5)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              page_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [23:0]       flash_addr_i,
  input  logic [7:0]        byte_i,
  input  logic [31:0]       buf_word_i,
  output logic [WIDX_W-1:0] buf_idx_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  output logic              cs_no,
  output logic              done_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, data_off, prog_last, frame_last;
  logic             launch_q, cs_q;
  logic [1:0]       lane;

  assign data_off  = idx_q - IDX_W'(4);
  assign buf_idx_o = data_off[WIDX_W+1:2];
  assign lane      = data_off[1:0];
  assign prog_last = page_i ? (IDX_W'(fill_i) << 2) + IDX_W'(3) : IDX_W'(4);

  always_comb begin
    sh_tx_o    = 8'h00;
    frame_last = '0;
    case (state_q)
      S_WREN: sh_tx_o = OP_WREN;
      S_PROG: begin
        frame_last = prog_last;
        case (idx_q)
          IDX_W'(0): sh_tx_o = OP_PROG;
          IDX_W'(1): sh_tx_o = flash_addr_i[23:16];
          IDX_W'(2): sh_tx_o = flash_addr_i[15:8];
          IDX_W'(3): sh_tx_o = flash_addr_i[7:0];
          default:   sh_tx_o = page_i ? buf_word_i[8*lane +: 8] : byte_i;
        endcase
      end
      S_POLL: begin
        frame_last = IDX_W'(1);
        sh_tx_o    = (idx_q == '0) ? OP_RDSR : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      launch_q <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      launch_q <= 1'b0;
      case (state_q)
        S_IDLE: if (go_i) begin
          if (page_i && fill_i == '0) state_q <= S_DONE;
          else begin
            state_q  <= S_WREN;
            idx_q    <= '0;
            cs_q     <= 1'b0;
            launch_q <= 1'b1;
          end
        end
        S_WREN, S_PROG, S_POLL: if (sh_done_i) begin
          if (idx_q == frame_last) begin
            cs_q  <= 1'b1;
            idx_q <= '0;
            case (state_q)
              S_WREN:  state_q <= S_GAP1;
              S_PROG:  state_q <= S_GAP2;
              default: state_q <= sh_rx_i[0] ? S_GAP2 : S_DONE;
            endcase
          end else begin
            idx_q    <= idx_q + 1'b1;
            launch_q <= 1'b1;
          end
        end
        S_GAP1: begin
          state_q  <= S_PROG;
          cs_q     <= 1'b0;
          launch_q <= 1'b1;
        end
        S_GAP2: begin
          state_q  <= S_POLL;
          cs_q     <= 1'b0;
          launch_q <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sh_start_o = launch_q;
  assign cs_no      = cs_q;
  assign done_o     = (state_q == S_DONE);
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int PAGE_WORDS = 64,
  localparam int WIDX_W = $clog2(PAGE_WORDS),
  localparam int FILL_W = $clog2(PAGE_WORDS + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        spi_sck_o,
  output logic        spi_cs_no,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  logic              go_w, page_w, done_w, push_w;
  logic [23:0]       faddr_w;
  logic [7:0]        byte_w, tx_w, rx_w;
  logic [FILL_W-1:0] fill_w;
  logic [WIDX_W-1:0] push_idx_w, rd_idx_w;
  logic [31:0]       word_w;
  logic              start_w, sh_done_w;

  fpw_regs #(.PAGE_WORDS(PAGE_WORDS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .done_i(done_w),
    .go_o(go_w), .page_o(page_w), .flash_addr_o(faddr_w),
    .byte_o(byte_w), .fill_o(fill_w),
    .push_o(push_w), .push_idx_o(push_idx_w)
  );

  fpw_buf #(.PAGE_WORDS(PAGE_WORDS)) u_buf (
    .clk_i, .push_i(push_w), .waddr_i(push_idx_w), .wdata_i(reg_wdata_i),
    .raddr_i(rd_idx_w), .rdata_o(word_w)
  );

  fpw_seq #(.PAGE_WORDS(PAGE_WORDS)) u_seq (
    .clk_i, .rst_ni,
    .go_i(go_w), .page_i(page_w), .fill_i(fill_w),
    .flash_addr_i(faddr_w), .byte_i(byte_w),
    .buf_word_i(word_w), .buf_idx_o(rd_idx_w),
    .sh_done_i(sh_done_w), .sh_rx_i(rx_w),
    .sh_start_o(start_w), .sh_tx_o(tx_w),
    .cs_no(spi_cs_no), .done_o(done_w)
  );

  fpw_shift u_shift (
    .clk_i, .rst_ni,
    .start_i(start_w), .tx_i(tx_w), .miso_i(spi_miso_i),
    .sck_o(spi_sck_o), .mosi_o(spi_mosi_o),
    .done_o(sh_done_w), .rx_o(rx_w)
  );
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int PAGE_WORDS = 64,
  localparam int FILL_W = $clog2(PAGE_WORDS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spi_cs_no,
  input logic              spi_sck_o,
  input logic              go_w,
  input logic [FILL_W-1:0] fill_w,
  input logic [7:0]        byte_w,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i
);
  a_r10_sck_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);

  a_r6_frame_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> go_w);

  a_r6_clear_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(go_w) |-> spi_cs_no);

  a_r8_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_w <= FILL_W'(PAGE_WORDS));

  a_r9_byte_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_w && reg_we_i && reg_addr_i == 3'd4) |=> $stable(byte_w));

  a_r8_fill_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_w && $past(go_w)) |-> (fill_w == $past(fill_w)) || !go_w || fill_w == '0);
endmodule

bind flash_page_writer flash_page_writer_chk #(.PAGE_WORDS(PAGE_WORDS)) u_chk (
  .clk_i, .rst_ni, .spi_cs_no, .spi_sck_o,
  .go_w(go_w), .fill_w(fill_w), .byte_w(byte_w),
  .reg_we_i, .reg_addr_i
);

// File: tb/flash_page_writer_tb_top.sv
module flash_page_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, cs_n, mosi;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_page_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // flash model
  logic [7:0] fmem [int];
  logic [7:0] fb [$];
  logic [7:0] sr = '0;
  logic [7:0] st = '0;
  int bitc = 0;
  int wip = 0;
  bit wel = 0;
  int n_wren = 0, n_pp = 0, n_rdsr = 0, n_bad = 0;
  int pp_len = 0;
  int pp_addr = 0;

  always @(negedge cs_n) begin
    bitc = 0;
    fb.delete();
    st = {7'b0, wip > 0};
  end

  always @(posedge sck) if (!cs_n) begin
    sr = {sr[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0) fb.push_back(sr);
  end

  always @(negedge sck) if (!cs_n) begin
    #1;
    if (bitc >= 8 && bitc < 16) miso = st[15 - bitc];
    else miso = 1'b0;
  end

  always @(posedge cs_n) if (fb.size() > 0) begin
    case (fb[0])
      8'h06: begin wel = 1; n_wren++; end
      8'h02: begin
        if (!wel || wip > 0 || fb.size() < 4) n_bad++;
        pp_addr = {8'h0, fb[1], fb[2], fb[3]};
        pp_len = fb.size() - 4;
        for (int i = 4; i < fb.size(); i++) fmem[pp_addr + i - 4] = fb[i];
        wel = 0;
        wip = 3;
        n_pp++;
      end
      8'h05: begin n_rdsr++; if (wip > 0) wip--; end
      default: n_bad++;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int k;
    k = 0;
    do begin rd(3'd0, v); k++; end while (v[4] && k < 20000);
    chk(req, {31'b0, v[4]}, 32'd0);
  endtask

  task automatic set_addr(input logic [23:0] a);
    wr(3'd1, {24'b0, a[7:0]});
    wr(3'd2, {24'b0, a[15:8]});
    wr(3'd3, {24'b0, a[23:16]});
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed + k * 13);
  endfunction

  task automatic push_words(input int seed, input int n);
    for (int w = 0; w < n; w++)
      wr(3'd6, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  function automatic int mem_bad(input int base, input int seed, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (!fmem.exists(base + k) || fmem[base + k] !== pat(seed, k)) bad++;
    return bad;
  endfunction

  initial begin
    #3000000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, a1, a2;
    int w0, p0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd7, v); chk("R1 fill", v, 32'd0);
    chk("R1 cs", {31'b0, cs_n}, 32'd1);
    chk("R1 sck", {31'b0, sck}, 32'd0);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R1 ctrl after release", v, 32'd0);

    // R2 R3 R6 R10 single byte
    set_addr(24'h123456);
    wr(3'd4, 32'hA5);
    w0 = n_wren; p0 = n_pp; r0 = n_rdsr;
    wr(3'd0, 32'h10);
    wait_idle("R6 single done");
    chk("R2 R10 byte programmed", {24'b0, fmem.exists(32'h123456) ? fmem[32'h123456] : 8'hxx}, 32'hA5);
    chk("R3 address order", pp_addr, 32'h123456);
    chk("R2 one data byte", pp_len, 32'd1);
    chk("R2 one wren", n_wren - w0, 32'd1);
    chk("R2 one prog", n_pp - p0, 32'd1);
    chk("R6 polls until ready", n_rdsr - r0, 32'd4);
    chk("R6 not busy at clear", wip, 32'd0);
    chk("R2 protocol order", n_bad, 32'd0);

    // R7 stepping across carry
    set_addr(24'h0000FE);
    for (int k = 0; k < 4; k++) begin
      wr(3'd4, 32'h30 + k);
      wr(3'd0, 32'h90);
      wait_idle("R7 step done");
      chk("R7 stepped byte", {24'b0, fmem.exists(32'hFE + k) ? fmem[32'hFE + k] : 8'hxx}, 32'h30 + k);
    end
    rd(3'd1, a0); rd(3'd2, a1); rd(3'd3, a2);
    chk("R7 address advanced", {8'b0, a2[7:0], a1[7:0], a0[7:0]}, 32'h000102);
    rd(3'd0, v); chk("R7 step bit kept", v, 32'h80);

    // R4 R8 full page
    wr(3'd5, 32'h1);
    rd(3'd7, v); chk("R8 fill reset on enable", v, 32'd0);
    push_words(7, 64);
    rd(3'd7, v); chk("R8 fill full", v, 32'd64);
    set_addr(24'h001000);
    wr(3'd0, 32'h90);
    wait_idle("R4 page done");
    chk("R4 page length", pp_len, 32'd256);
    chk("R4 page data", mem_bad(32'h1000, 7, 256), 32'd0);
    rd(3'd1, a0); rd(3'd2, a1); rd(3'd3, a2);
    chk("R7 page keeps address", {8'b0, a2[7:0], a1[7:0], a0[7:0]}, 32'h001000);
    rd(3'd7, v); chk("R8 fill cleared after page", v, 32'd0);

    // R5 partial page
    wr(3'd5, 32'h1);
    push_words(91, 3);
    rd(3'd7, v); chk("R5 partial fill", v, 32'd3);
    set_addr(24'h002000);
    wr(3'd0, 32'h10);
    wait_idle("R5 partial done");
    chk("R5 partial length", pp_len, 32'd12);
    chk("R5 partial data", mem_bad(32'h2000, 91, 12), 32'd0);
    chk("R5 nothing beyond", {31'b0, fmem.exists(32'h200C)}, 32'd0);

    // R5 empty page
    wr(3'd5, 32'h1);
    w0 = n_wren; p0 = n_pp;
    wr(3'd0, 32'h10);
    wait_idle("R5 empty done");
    chk("R5 empty no frames", (n_wren - w0) + (n_pp - p0), 32'd0);

    // R8 overflow
    wr(3'd5, 32'h1);
    push_words(200, 70);
    rd(3'd7, v); chk("R8 overflow ignored", v, 32'd64);
    wr(3'd5, 32'h1);
    rd(3'd7, v); chk("R8 re-enable resets", v, 32'd0);
    wr(3'd5, 32'h0);

    // R9 writes ignored while busy
    set_addr(24'h003000);
    wr(3'd4, 32'h77);
    wr(3'd0, 32'h10);
    wr(3'd1, 32'hFF);
    wr(3'd4, 32'h11);
    wr(3'd5, 32'h1);
    wait_idle("R9 busy done");
    chk("R9 data kept", {24'b0, fmem.exists(32'h3000) ? fmem[32'h3000] : 8'hxx}, 32'h77);
    rd(3'd1, v); chk("R9 address reg kept", v, 32'h00);
    rd(3'd4, v); chk("R9 byte reg kept", v, 32'h77);
    rd(3'd5, v); chk("R9 buffer ctrl kept", v, 32'h0);
    chk("R10 R2 protocol clean", n_bad, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule